// File: doc/BRIEF.md
# Pipelined Read Output Stage

This block is the registered data-out path of a synchronous burst memory. The memory array and the address generator sit outside it. Each clock edge, the block classifies the cycle from the address strobes and the chip selects. A cycle either starts an access, deselects the part, or keeps the current access going. The block then keeps a select state and a write flag. Read data from the array is captured into an output register one edge after the address is accepted, so read data reaches the bus one cycle late.

The bus enable is combinational. It needs a one-cycle delayed copy of the select state, no write in the current access, the active-low output enable `oe_n`, and a low sleep input. Both `oe_n` and `zz` act without waiting for a clock edge. While `zz` is high the clocked state freezes, so the output register keeps its contents. Selection is dropped during sleep, so the block always wakes up deselected. A synchronous reset also leaves the block deselected, with the output register cleared.

Top module: `burst_rdout_stage`

## Requirements
- R1: A read is accepted at edge k when a start cycle carries no effective write, or when the block is selected and the cycle keeps the access going without a write. At edge k+1 the output register loads `rd_data` and `dout_valid` goes high for the following cycle.
- R2: A cycle deselects the block in two cases. Either `ce_n` is high while `ads_ctrl_n` is low. Or `ce_n` is low, `cs_hi` is low or `cs_lo_n` is high, and either strobe is low. A start is a strobe cycle with `ce_n` low, `cs_hi` high and `cs_lo_n` low.
- R3: After a deselect is sampled at edge k, the bus is still driven with the data registered at edge k during the next cycle. It is released after edge k+1.
- R4: `dq_oe` is high only when the delayed select state is set, no write flag is set, `oe_n` is low and `zz` is low. `oe_n` acts with no clock edge.
- R5: A write is requested when `gw_n` is low, or when `bwe_n` is low and at least one bit of `bw_n` is low. With `bwe_n` high, `bw_n` has no effect. An accepted write holds `dq_oe` low in the cycle after its edge. A start with `ads_proc_n` low (and `ce_n` low) is always a read, whatever the write inputs are.
- R6: While `zz` is high, `dq_oe` is low at once. The output register and `dout_valid` do not change at any edge.
- R7: The block leaves sleep deselected. Reset clears the select state, the output register and `dout_valid`.
- R8: A cycle with `ads_ctrl_n` high, and with `ads_proc_n` high or `ce_n` high, keeps the select state whatever `ce_n`, `cs_hi` and `cs_lo_n` are. `ads_proc_n` is ignored while `ce_n` is high. `ads_ctrl_n` is not gated by `ce_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| zz | input | 1 | Sleep: freezes the clocked state and releases the bus |
| oe_n | input | 1 | Active-low output enable, asynchronous |
| ce_n | input | 1 | Active-low chip enable, also gates `ads_proc_n` |
| cs_hi | input | 1 | Active-high chip select |
| cs_lo_n | input | 1 | Active-low chip select |
| ads_proc_n | input | 1 | Processor-side address strobe, active low |
| ads_ctrl_n | input | 1 | Controller-side address strobe, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Lane write gate, active low |
| bw_n | input | DATA_W/LANE_W | Per-lane write selects, active low |
| rd_data | input | DATA_W | Read data from the array for the accepted address |
| dq_o | output | DATA_W | Output register contents for the bus driver |
| dq_oe | output | 1 | Bus drive enable |
| dout_valid | output | 1 | Output register was loaded by a read at the last edge |

## Verification
The bench builds the block with a 24-bit data path and 8-bit lanes. This gives three lanes, an odd count that is not a power of two. It exercises the per-lane register generate and the any-lane-low write reduction on a width that a power-of-two layout would hide. Each read beat carries a pattern that differs in every lane, so a swapped or stale lane shows up on `dq_o`. The directed scenarios cover several cases:
- the cycle boundary of the one-cycle deselect;
- asynchronous `oe_n` and `zz` changes in the middle of a cycle;
- strobe and chip-select combinations that must be ignored;
- byte-lane write masks with `bwe_n` both low and high.

// File: rtl/brst_out_pkg.sv
package brst_out_pkg;

  // Cycle classes seen by the output stage at each edge
  typedef enum logic [1:0] {
    CYC_KEEP  = 2'd0,  // no effective address strobe: access continues or waits
    CYC_START = 2'd1,  // strobe with chip fully selected
    CYC_DESEL = 2'd2   // strobe with chip not selected
  } cyc_kind_e;

  typedef struct packed {
    cyc_kind_e kind;
    logic      wr;     // access of this cycle is a write
  } cyc_dec_t;

endpackage

// File: rtl/brst_out_decode.sv
module brst_out_decode
  import brst_out_pkg::*;
#(
  parameter int NLANES = 4
) (
  input  logic              ce_n,
  input  logic              cs_hi,
  input  logic              cs_lo_n,
  input  logic              ads_proc_n,
  input  logic              ads_ctrl_n,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [NLANES-1:0] bw_n,
  output cyc_dec_t          dec
);

  logic chip_ok;
  logic proc_hit;
  logic ctrl_hit;
  logic lane_wr;
  logic wr_req;

  always_comb begin
    chip_ok  = !ce_n && cs_hi && !cs_lo_n;
    // processor strobe only counts while chip enable is low
    proc_hit = !ce_n && !ads_proc_n;
    // controller strobe is not gated by chip enable
    ctrl_hit = !ads_ctrl_n;
    lane_wr  = !bwe_n && !(&bw_n);
    wr_req   = !gw_n || lane_wr;

    if (!(proc_hit || ctrl_hit)) begin
      dec.kind = CYC_KEEP;
    end else if (chip_ok) begin
      dec.kind = CYC_START;
    end else begin
      dec.kind = CYC_DESEL;
    end

    // a processor-strobe start is always a read
    dec.wr = (dec.kind != CYC_DESEL) && wr_req && !proc_hit;
  end

endmodule

// File: rtl/brst_out_track.sv
module brst_out_track
  import brst_out_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     zz,
  input  cyc_dec_t dec,
  output logic     selected_q,
  output logic     write_q,
  output logic     rd_pend_q,
  output logic     out_sel_q
);

  logic active;

  always_comb begin
    active = (dec.kind == CYC_START) ||
             ((dec.kind == CYC_KEEP) && selected_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      selected_q <= 1'b0;
      write_q    <= 1'b0;
      rd_pend_q  <= 1'b0;
      out_sel_q  <= 1'b0;
    end else if (zz) begin
      // sleep: hold write flag, abandon access, wake deselected
      selected_q <= 1'b0;
      rd_pend_q  <= 1'b0;
      out_sel_q  <= 1'b0;
    end else begin
      case (dec.kind)
        CYC_START: selected_q <= 1'b1;
        CYC_DESEL: selected_q <= 1'b0;
        default:   selected_q <= selected_q;
      endcase
      write_q   <= active && dec.wr;
      rd_pend_q <= active && !dec.wr;
      out_sel_q <= selected_q;
    end
  end

  assert_desel_R2: assert property (@(posedge clk) disable iff (rst)
    (dec.kind == CYC_DESEL && !zz) |=> !selected_q);

  assert_keep_sel_R8: assert property (@(posedge clk) disable iff (rst)
    (dec.kind == CYC_KEEP && !zz) |=> $stable(selected_q));

  assert_wake_desel_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(zz) |-> !selected_q);

  assert_sel_lag_R3: assert property (@(posedge clk) disable iff (rst)
    (!zz ##1 !zz) |-> (out_sel_q == $past(selected_q)));

endmodule

// File: rtl/brst_out_reg.sv
module brst_out_reg #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              zz,
  input  logic              cap,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] dout_q,
  output logic              dout_valid
);

  localparam int NLANES = DATA_W / LANE_W;

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        dout_q[g*LANE_W +: LANE_W] <= '0;
      end else if (!zz && cap) begin
        dout_q[g*LANE_W +: LANE_W] <= rd_data[g*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_valid <= 1'b0;
    end else if (!zz) begin
      dout_valid <= cap;
    end
  end

  assert_read_latency_R1: assert property (@(posedge clk) disable iff (rst)
    (cap && !zz) |=> (dout_valid && dout_q == $past(rd_data)));

  assert_sleep_hold_R6: assert property (@(posedge clk) disable iff (rst)
    zz |=> ($stable(dout_q) && $stable(dout_valid)));

endmodule

// File: rtl/burst_rdout_stage.sv
module burst_rdout_stage
  import brst_out_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int NLANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              zz,
  input  logic              oe_n,
  input  logic              ce_n,
  input  logic              cs_hi,
  input  logic              cs_lo_n,
  input  logic              ads_proc_n,
  input  logic              ads_ctrl_n,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [NLANES-1:0] bw_n,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe,
  output logic              dout_valid
);

  cyc_dec_t dec;
  logic     selected_q;
  logic     write_q;
  logic     rd_pend_q;
  logic     out_sel_q;
  logic     will_write;

  brst_out_decode #(.NLANES(NLANES)) u_decode (
    .ce_n       (ce_n),
    .cs_hi      (cs_hi),
    .cs_lo_n    (cs_lo_n),
    .ads_proc_n (ads_proc_n),
    .ads_ctrl_n (ads_ctrl_n),
    .gw_n       (gw_n),
    .bwe_n      (bwe_n),
    .bw_n       (bw_n),
    .dec        (dec)
  );

  brst_out_track u_track (
    .clk        (clk),
    .rst        (rst),
    .zz         (zz),
    .dec        (dec),
    .selected_q (selected_q),
    .write_q    (write_q),
    .rd_pend_q  (rd_pend_q),
    .out_sel_q  (out_sel_q)
  );

  brst_out_reg #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_oreg (
    .clk        (clk),
    .rst        (rst),
    .zz         (zz),
    .cap        (rd_pend_q),
    .rd_data    (rd_data),
    .dout_q     (dq_o),
    .dout_valid (dout_valid)
  );

  // asynchronous output buffer gate
  assign dq_oe = out_sel_q && !write_q && !oe_n && !zz;

  always_comb begin
    will_write = !zz && dec.wr &&
                 ((dec.kind == CYC_START) ||
                  ((dec.kind == CYC_KEEP) && selected_q));
  end

  assert_write_off_R5: assert property (@(posedge clk) disable iff (rst)
    will_write |=> !dq_oe);

  assert_reset_clear_R7: assert property (@(posedge clk)
    rst |=> (!dq_oe && !dout_valid && dq_o == '0));

endmodule

// File: tb/burst_rdout_stage_bench.sv
module burst_rdout_stage_bench;

  localparam int DW = 24;
  localparam int LW = 8;
  localparam int NL = DW / LW;

  logic          clk = 1'b0;
  logic          rst;
  logic          zz, oe_n, ce_n, cs_hi, cs_lo_n;
  logic          ads_proc_n, ads_ctrl_n, gw_n, bwe_n;
  logic [NL-1:0] bw_n;
  logic [DW-1:0] rd_data;
  logic [DW-1:0] dq_o;
  logic          dq_oe, dout_valid;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  burst_rdout_stage #(.DATA_W(DW), .LANE_W(LW)) u_burst_rdout_stage (
    .clk(clk), .rst(rst), .zz(zz), .oe_n(oe_n), .ce_n(ce_n), .cs_hi(cs_hi),
    .cs_lo_n(cs_lo_n), .ads_proc_n(ads_proc_n), .ads_ctrl_n(ads_ctrl_n),
    .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .rd_data(rd_data),
    .dq_o(dq_o), .dq_oe(dq_oe), .dout_valid(dout_valid)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    ce_n = 1'b1; cs_hi = 1'b0; cs_lo_n = 1'b1;
    ads_proc_n = 1'b1; ads_ctrl_n = 1'b1;
    gw_n = 1'b1; bwe_n = 1'b1; bw_n = '1;
    oe_n = 1'b0; zz = 1'b0;
  endtask

  // start a read with the processor strobe and land first beat d on the bus
  task automatic open_read(input logic [DW-1:0] d);
    ce_n = 1'b0; cs_hi = 1'b1; cs_lo_n = 1'b0; ads_proc_n = 1'b0;
    step();
    ads_proc_n = 1'b1; rd_data = d;
    step();
  endtask

  task automatic t_reset();
    rst = 1'b1; idle_inputs(); rd_data = 24'hA5A5A5;
    step(); step();
    chk("R7", "reset dq_oe", {31'd0, dq_oe}, 32'd0);
    chk("R7", "reset valid", {31'd0, dout_valid}, 32'd0);
    chk("R7", "reset dq_o", {8'd0, dq_o}, 32'd0);
    rst = 1'b0;
    step();
  endtask

  task automatic t_read();
    ce_n = 1'b0; cs_hi = 1'b1; cs_lo_n = 1'b0; ads_proc_n = 1'b0;
    rd_data = 24'h0;
    step();
    chk("R1", "bus before data", {31'd0, dq_oe}, 32'd0);
    chk("R1", "valid before data", {31'd0, dout_valid}, 32'd0);
    ads_proc_n = 1'b1; rd_data = 24'h123456;
    step();
    chk("R1", "first beat", {8'd0, dq_o}, 32'h123456);
    chk("R1", "first valid", {31'd0, dout_valid}, 32'd1);
    chk("R4", "bus on", {31'd0, dq_oe}, 32'd1);
    rd_data = 24'hFEDCBA;
    step();
    chk("R1", "continue beat", {8'd0, dq_o}, 32'hFEDCBA);
    idle_inputs(); ads_ctrl_n = 1'b0;
    step(); step();
    ads_ctrl_n = 1'b1;
  endtask

  task automatic t_deselect_lag();
    open_read(24'h010203);
    ce_n = 1'b1; ads_ctrl_n = 1'b0; rd_data = 24'h0A0B0C;
    step();
    chk("R3", "still driving", {31'd0, dq_oe}, 32'd1);
    chk("R3", "last data", {8'd0, dq_o}, 32'h0A0B0C);
    ads_ctrl_n = 1'b1;
    step();
    chk("R3", "released", {31'd0, dq_oe}, 32'd0);
    chk("R2", "no read after desel", {31'd0, dout_valid}, 32'd0);
  endtask

  task automatic t_deselect_cs();
    open_read(24'h111111);
    ce_n = 1'b0; cs_hi = 1'b0; ads_ctrl_n = 1'b0;
    step(); ads_ctrl_n = 1'b1; step();
    chk("R2", "cs_hi low desel", {31'd0, dq_oe}, 32'd0);
    open_read(24'h222222);
    ce_n = 1'b0; cs_hi = 1'b1; cs_lo_n = 1'b1; ads_proc_n = 1'b0;
    step(); ads_proc_n = 1'b1; step();
    chk("R2", "cs_lo_n high desel", {31'd0, dq_oe}, 32'd0);
  endtask

  task automatic t_oe_async();
    open_read(24'h333333);
    #1 oe_n = 1'b1;
    #1 chk("R4", "oe_n high no edge", {31'd0, dq_oe}, 32'd0);
    oe_n = 1'b0;
    #1 chk("R4", "oe_n low no edge", {31'd0, dq_oe}, 32'd1);
    @(negedge clk);
    idle_inputs(); ads_ctrl_n = 1'b0; step(); step(); ads_ctrl_n = 1'b1;
  endtask

  task automatic t_writes();
    open_read(24'h444444);
    gw_n = 1'b0;
    step();
    chk("R5", "global write off", {31'd0, dq_oe}, 32'd0);
    gw_n = 1'b1; bwe_n = 1'b0; bw_n = 3'b101;
    step();
    chk("R5", "lane write off", {31'd0, dq_oe}, 32'd0);
    bwe_n = 1'b1; bw_n = 3'b000;
    step();
    chk("R5", "bwe_n high masks lanes", {31'd0, dq_oe}, 32'd1);
    bwe_n = 1'b0; bw_n = 3'b111;
    step();
    chk("R5", "no lane selected reads", {31'd0, dq_oe}, 32'd1);
    bwe_n = 1'b1;
    ads_proc_n = 1'b0; gw_n = 1'b0;
    step();
    chk("R5", "proc start is read", {31'd0, dq_oe}, 32'd1);
    ads_proc_n = 1'b1; gw_n = 1'b1; rd_data = 24'h5A5A5A;
    step();
    chk("R5", "proc start data", {8'd0, dq_o}, 32'h5A5A5A);
    ads_ctrl_n = 1'b0; gw_n = 1'b0;
    step();
    chk("R5", "ctrl start write", {31'd0, dq_oe}, 32'd0);
    idle_inputs(); ads_ctrl_n = 1'b0; step(); step(); ads_ctrl_n = 1'b1;
  endtask

  task automatic t_ignore_cs();
    open_read(24'h555555);
    ce_n = 1'b1; cs_hi = 1'b0; cs_lo_n = 1'b1; rd_data = 24'h6789AB;
    step();
    chk("R8", "keep ignores selects", {31'd0, dq_oe}, 32'd1);
    ads_proc_n = 1'b0; rd_data = 24'hCDEF01;
    step();
    chk("R8", "proc strobe gated", {8'd0, dq_o}, 32'hCDEF01);
    step();
    chk("R8", "still selected", {31'd0, dq_oe}, 32'd1);
    ads_proc_n = 1'b1; ads_ctrl_n = 1'b0;
    step(); step();
    chk("R8", "ctrl strobe ungated", {31'd0, dq_oe}, 32'd0);
    ads_ctrl_n = 1'b1;
  endtask

  task automatic t_sleep();
    open_read(24'h778899);
    zz = 1'b1; rd_data = 24'h000000;
    #1 chk("R6", "bus off at once", {31'd0, dq_oe}, 32'd0);
    @(negedge clk);
    step(); step();
    chk("R6", "data retained", {8'd0, dq_o}, 32'h778899);
    chk("R6", "valid frozen", {31'd0, dout_valid}, 32'd1);
    zz = 1'b0;
    #1 chk("R7", "wake bus off", {31'd0, dq_oe}, 32'd0);
    @(negedge clk);
    step();
    chk("R7", "wake deselected", {31'd0, dq_oe}, 32'd0);
    chk("R6", "data kept after wake", {8'd0, dq_o}, 32'h778899);
    idle_inputs();
  endtask

  initial begin
    #150000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1;
    idle_inputs();
    rd_data = '0;
    @(negedge clk);
    t_reset();
    t_read();
    t_deselect_lag();
    t_deselect_cs();
    t_oe_async();
    t_writes();
    t_ignore_cs();
    t_sleep();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule